// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple host request port and a four-bank synchronous DRAM with a 16-bit data path. After reset it runs the power-up sequence. It waits a programmable settling time, precharges every bank, issues two auto-refresh commands and programs the mode register. Only then does it accept host traffic. Each host request carries a 22-bit word address, with the bank in bits 21:20, the row in 19:8 and the column in 7:0. The request also carries a read/write flag, an auto-precharge flag, write data and two byte enables. The sequencer turns it into the activate, precharge and column commands the memory needs, and it inserts idle cycles to honour the activate-to-column, precharge, refresh and mode-load spacings, all given as parameters in clock cycles.

At most one row in one bank is held open. A request that hits the open row is served at once. A request to another row or bank first closes the open one. A free-running interval counter raises a refresh need. That need outranks a waiting host request as soon as the current access has finished, and any open row is closed before the refresh. Read data returns on a response strobe a fixed number of cycles after the read command, set by the programmed CAS latency.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is high, CKE is low, the command is NOP, both DQM bits are high, no read response is given and req_ready is low. CKE is high in every cycle after reset.
- R2: The command is NOP for INIT_CYCLES cycles after reset. Then come PRECHARGE with A10 high, AUTO REFRESH T_RP cycles later, a second AUTO REFRESH T_RFC cycles after that, and LOAD MODE T_RFC cycles later. The LOAD MODE address is CAS_LAT in bits 6:4 with all other bits zero, which selects burst length 1 and sequential order.
- R3: Commands appear on {CS#,RAS#,CAS#,WE#} as NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, AUTO REFRESH=0001 and LOAD MODE=0000. Every cycle that needs no command is NOP.
- R4: A request made while no row is open produces ACTIVE with the bank on A13:12 and the row on A11:0. The column command follows T_RCD cycles later.
- R5: A request that hits the open row is accepted (req_ready high) in the cycle its READ or WRITE goes out. The address carries the bank on A13:12, the auto-precharge flag on A10, the column on A7:0 and zero elsewhere. A WRITE drives the write data with the output enable high and DQM equal to the inverted byte enables (bit 1 is the upper byte) in that cycle only.
- R6: A request to a row other than the open one first issues PRECHARGE of the open bank, with A10 low and that bank on A13:12. ACTIVE follows T_RP cycles later.
- R7: The next command follows a READ by CAS_LAT+1 cycles and a WRITE by T_WR cycles. When auto-precharge is set, T_RP is added and the row counts as closed.
- R8: A refresh need arises every REFRESH_INTERVAL cycles, counted from the LOAD MODE cycle. When the sequencer is free it is served before any host request. An open row is first closed by PRECHARGE with A10 high, and AUTO REFRESH follows T_RP later. The next command comes T_RFC after the refresh.
- R9: A read response strobe appears CAS_LAT+1 cycles after each READ, carrying the memory data bus as sampled at that clock edge.
- R10: DQM is 00 in every cycle after the LOAD MODE cycle, except write cycles with a byte enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after this access |
| req_addr | input | 22 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| rsp_valid | output | 1 | Read data strobe |
| rsp_data | output | 16 | Read data |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write strobe, active low |
| sd_addr | output | 14 | Multiplexed address, bank on bits 13:12 |
| sd_dqm | output | 2 | Data mask, bit 1 = upper byte |
| sd_dq_out | output | 16 | Write data to the memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 16 | Read data from the memory |

## Verification
The interesting collision is a refresh need that comes due while a host request is already waiting, sometimes with a row open and sometimes with every bank closed. The bench streams back-to-back requests that mix row hits, row misses and auto-precharge across several refresh intervals, and it leaves one idle gap after a closing access. A behavioural model with its own interval counter predicts, cycle by cycle, whether the next command is the closing precharge, the refresh or the host's command. Any disagreement in command, address, mask, data enable or response timing is reported.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int BANK_W = 2;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 8;
    localparam int DATA_W = 16;
    localparam int BE_W   = DATA_W / 8;
    localparam int HADDR_W = BANK_W + ROW_W + COL_W;
    localparam int SADDR_W = BANK_W + ROW_W;
    localparam int AP_BIT  = 10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } host_addr_t;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_WAIT,
        ST_INIT_REF1,
        ST_INIT_REF2,
        ST_INIT_MRS,
        ST_IDLE
    } seq_state_e;

    // Mode word: burst length 1, sequential, latency in bits 6:4
    function automatic logic [SADDR_W-1:0] mode_word(input int cas_lat);
        logic [SADDR_W-1:0] w;
        w = '0;
        w[6:4] = 3'(cas_lat);
        return w;
    endfunction

    function automatic logic [SADDR_W-1:0] col_addr(input logic [BANK_W-1:0] bank,
                                                     input logic ap,
                                                     input logic [COL_W-1:0] col);
        logic [SADDR_W-1:0] a;
        a = '0;
        a[SADDR_W-1 -: BANK_W] = bank;
        a[AP_BIT] = ap;
        a[COL_W-1:0] = col;
        return a;
    endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer
    import sdram_seq_pkg::*;
#(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = en && (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (en) cnt <= tick ? '0 : cnt + 1'b1;
            pend <= (pend & ~ack) | tick;
        end
    end

    // R8
    pend_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> !pend);

endmodule

// File: rtl/sdr_read_capture.sv
module sdr_read_capture
    import sdram_seq_pkg::*;
#(
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [CAS_LAT-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            stage     <= {stage[CAS_LAT-2:0], rd_issue};
            rsp_valid <= stage[CAS_LAT-1];
            if (stage[CAS_LAT-1]) rsp_data <= dq_in;
        end
    end

    // R9
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd_issue, CAS_LAT + 1));

endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
    import sdram_seq_pkg::*;
#(
    parameter int INIT_CYCLES = 20000,
    parameter int T_RCD       = 2,
    parameter int T_RP        = 2,
    parameter int T_RFC       = 7,
    parameter int T_MRD       = 2,
    parameter int T_WR        = 2,
    parameter int CAS_LAT     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic               req_autopre,
    input  host_addr_t         req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [BE_W-1:0]    req_be,
    input  logic               ref_pend,
    output logic               ref_ack,
    output logic               req_ready,
    output logic               init_done,
    output logic               rd_issue,
    output sd_cmd_e            cmd,
    output logic [SADDR_W-1:0] sd_addr,
    output logic               cke,
    output logic [BE_W-1:0]    dqm,
    output logic [DATA_W-1:0]  dq_out,
    output logic               dq_oe
);
    localparam int CW = $clog2(INIT_CYCLES + T_RCD + T_RP + T_RFC + T_MRD + T_WR + CAS_LAT + 2);
    localparam logic [SADDR_W-1:0] ALL_BANKS = SADDR_W'(1) << AP_BIT;

    seq_state_e         state, nxt_state;
    logic [CW-1:0]      wcnt;
    logic               open_valid;
    logic [BANK_W-1:0]  open_bank;
    logic [ROW_W-1:0]   open_row;

    logic idle, hit, do_ref_pre, do_ref, do_rw, do_miss_pre, do_act;
    logic [CW-1:0] rw_wait;

    always_comb begin
        idle        = (state == ST_IDLE);
        hit         = open_valid && (req_addr.bank == open_bank) && (req_addr.row == open_row);
        do_ref_pre  = idle && ref_pend && open_valid;
        do_ref      = idle && ref_pend && !open_valid;
        do_rw       = idle && !ref_pend && req_valid && hit;
        do_miss_pre = idle && !ref_pend && req_valid && open_valid && !hit;
        do_act      = idle && !ref_pend && req_valid && !open_valid;
        rw_wait     = CW'((req_we ? T_WR : CAS_LAT + 1) + (req_autopre ? T_RP : 0) - 2);
    end

    assign req_ready = do_rw;
    assign ref_ack   = do_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_POWERUP;
            nxt_state  <= ST_IDLE;
            wcnt       <= CW'(INIT_CYCLES - 1);
            cmd        <= CMD_NOP;
            sd_addr    <= '0;
            cke        <= 1'b0;
            dqm        <= '1;
            dq_out     <= '0;
            dq_oe      <= 1'b0;
            rd_issue   <= 1'b0;
            init_done  <= 1'b0;
            open_valid <= 1'b0;
            open_bank  <= '0;
            open_row   <= '0;
        end else begin
            cke      <= 1'b1;
            cmd      <= CMD_NOP;
            sd_addr  <= '0;
            dq_oe    <= 1'b0;
            rd_issue <= 1'b0;
            dqm      <= init_done ? '0 : '1;
            case (state)
                ST_POWERUP: begin
                    if (wcnt == '0) begin
                        cmd       <= CMD_PRE;
                        sd_addr   <= ALL_BANKS;
                        wcnt      <= CW'(T_RP - 2);
                        nxt_state <= ST_INIT_REF1;
                        state     <= ST_WAIT;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (wcnt == '0) state <= nxt_state;
                    else            wcnt  <= wcnt - 1'b1;
                end
                ST_INIT_REF1: begin
                    cmd       <= CMD_REF;
                    wcnt      <= CW'(T_RFC - 2);
                    nxt_state <= ST_INIT_REF2;
                    state     <= ST_WAIT;
                end
                ST_INIT_REF2: begin
                    cmd       <= CMD_REF;
                    wcnt      <= CW'(T_RFC - 2);
                    nxt_state <= ST_INIT_MRS;
                    state     <= ST_WAIT;
                end
                ST_INIT_MRS: begin
                    cmd       <= CMD_LMR;
                    sd_addr   <= mode_word(CAS_LAT);
                    init_done <= 1'b1;
                    wcnt      <= CW'(T_MRD - 2);
                    nxt_state <= ST_IDLE;
                    state     <= ST_WAIT;
                end
                ST_IDLE: begin
                    nxt_state <= ST_IDLE;
                    if (do_ref_pre) begin
                        cmd        <= CMD_PRE;
                        sd_addr    <= ALL_BANKS;
                        open_valid <= 1'b0;
                        wcnt       <= CW'(T_RP - 2);
                        state      <= ST_WAIT;
                    end else if (do_ref) begin
                        cmd   <= CMD_REF;
                        wcnt  <= CW'(T_RFC - 2);
                        state <= ST_WAIT;
                    end else if (do_rw) begin
                        cmd     <= req_we ? CMD_WR : CMD_RD;
                        sd_addr <= col_addr(req_addr.bank, req_autopre, req_addr.col);
                        if (req_we) begin
                            dq_out <= req_wdata;
                            dq_oe  <= 1'b1;
                            dqm    <= ~req_be;
                        end else begin
                            rd_issue <= 1'b1;
                        end
                        if (req_autopre) open_valid <= 1'b0;
                        wcnt  <= rw_wait;
                        state <= ST_WAIT;
                    end else if (do_miss_pre) begin
                        cmd        <= CMD_PRE;
                        sd_addr    <= {open_bank, {ROW_W{1'b0}}};
                        open_valid <= 1'b0;
                        wcnt       <= CW'(T_RP - 2);
                        state      <= ST_WAIT;
                    end else if (do_act) begin
                        cmd        <= CMD_ACT;
                        sd_addr    <= {req_addr.bank, req_addr.row};
                        open_valid <= 1'b1;
                        open_bank  <= req_addr.bank;
                        open_row   <= req_addr.row;
                        wcnt       <= CW'(T_RCD - 2);
                        state      <= ST_WAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    act_then_nop_chk: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_ACT |=> cmd == CMD_NOP);

    // R8
    ref_on_need_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF && init_done) |-> $past(ref_pend));

    // R10
    read_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_RD |-> dqm == '0);

    // R1
    cke_on_command_chk: assert property (@(posedge clk) disable iff (rst)
        cmd != CMD_NOP |-> cke);

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int INIT_CYCLES      = 20000,
    parameter int REFRESH_INTERVAL = 1560,
    parameter int T_RCD            = 2,
    parameter int T_RP             = 2,
    parameter int T_RFC            = 7,
    parameter int T_MRD            = 2,
    parameter int T_WR             = 2,
    parameter int CAS_LAT          = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_we,
    input  logic        req_autopre,
    input  logic [21:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [1:0]  req_be,
    output logic        rsp_valid,
    output logic [15:0] rsp_data,
    output logic        sd_cke,
    output logic        sd_cs_n,
    output logic        sd_ras_n,
    output logic        sd_cas_n,
    output logic        sd_we_n,
    output logic [13:0] sd_addr,
    output logic [1:0]  sd_dqm,
    output logic [15:0] sd_dq_out,
    output logic        sd_dq_oe,
    input  logic [15:0] sd_dq_in
);
    sd_cmd_e cmd;
    logic    ref_pend, ref_ack, init_done, rd_issue;

    sdr_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_refresh (
        .clk  (clk),
        .rst  (rst),
        .en   (init_done),
        .ack  (ref_ack),
        .pend (ref_pend)
    );

    sdr_cmd_fsm #(
        .INIT_CYCLES (INIT_CYCLES),
        .T_RCD       (T_RCD),
        .T_RP        (T_RP),
        .T_RFC       (T_RFC),
        .T_MRD       (T_MRD),
        .T_WR        (T_WR),
        .CAS_LAT     (CAS_LAT)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_we      (req_we),
        .req_autopre (req_autopre),
        .req_addr    (host_addr_t'(req_addr)),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .ref_pend    (ref_pend),
        .ref_ack     (ref_ack),
        .req_ready   (req_ready),
        .init_done   (init_done),
        .rd_issue    (rd_issue),
        .cmd         (cmd),
        .sd_addr     (sd_addr),
        .cke         (sd_cke),
        .dqm         (sd_dqm),
        .dq_out      (sd_dq_out),
        .dq_oe       (sd_dq_oe)
    );

    sdr_read_capture #(.CAS_LAT(CAS_LAT)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .rd_issue  (rd_issue),
        .dq_in     (sd_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: tb/sdram_seq_ctrl_tb.sv
module sdram_seq_ctrl_tb;

    localparam int CLK_NS = 10;
    localparam int INIT   = 40;
    localparam int RINT   = 150;
    localparam int RCD    = 2;
    localparam int RP     = 3;
    localparam int RFC    = 5;
    localparam int MRD    = 2;
    localparam int WR     = 2;
    localparam int CL     = 3;
    localparam int WATCHDOG = 20000;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_LMR = 4'b0000;

    logic        clk, rst;
    logic        req_valid, req_ready, req_we, req_autopre;
    logic [21:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  req_be;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [13:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    sdram_seq_ctrl #(
        .INIT_CYCLES(INIT), .REFRESH_INTERVAL(RINT), .T_RCD(RCD), .T_RP(RP),
        .T_RFC(RFC), .T_MRD(MRD), .T_WR(WR), .CAS_LAT(CL)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_autopre(req_autopre), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    initial begin
        clk = 0;
        forever #(CLK_NS/2) clk = ~clk;
    end

    task automatic chk(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp, input int cyc);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d %s: got %h expected %h", tag, cyc, what, got, exp);
        end
    endtask

    function automatic logic [15:0] fill(input int k);
        return 16'(k * 37) ^ 16'hC35A;
    endfunction

    logic [15:0] ref_mem [int];
    logic [15:0] dram_mem [int];

    function automatic logic [15:0] ref_rd(input int k);
        return ref_mem.exists(k) ? ref_mem[k] : fill(k);
    endfunction
    function automatic logic [15:0] dram_rd(input int k);
        return dram_mem.exists(k) ? dram_mem[k] : fill(k);
    endfunction

    typedef struct { int due; logic [15:0] d; } rdq_t;

    // Behavioural reference model, memory model and per-cycle comparison
    initial begin : model
        int cyc, busy, phase, tcount;
        bit pend, tim_on, m_init, m_open, mrs_now;
        logic [1:0]  ob;
        logic [11:0] orow;
        logic [1:0]  drow_bank;
        logic [11:0] drow [4];
        logic [3:0]  e_cmd, got_cmd;
        logic [13:0] e_addr;
        logic [1:0]  e_dqm;
        logic        e_oe, chk_a;
        logic [15:0] e_wd;
        string       tag;
        rdq_t        exp_q[$];
        rdq_t        dram_q[$];
        int          k;
        logic [1:0]  rb;
        logic [11:0] rr;
        logic [7:0]  rc;
        cyc = 0; busy = 0; phase = 0; tcount = 0; pend = 0; tim_on = 0;
        m_init = 0; m_open = 0; ob = 0; orow = 0;
        for (int i = 0; i < 4; i++) drow[i] = 0;
        sd_dq_in = 16'hDEAD;
        forever begin
            @(posedge clk);
            #(CLK_NS/4);
            got_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (rst) begin
                // R1 reset state
                chk("R1", "cke", 32'(sd_cke), 0, 0);
                chk("R1", "cmd", 32'(got_cmd), 32'(C_NOP), 0);
                chk("R1", "dqm", 32'(sd_dqm), 3, 0);
                chk("R1", "rsp_valid", 32'(rsp_valid), 0, 0);
                chk("R1", "req_ready", 32'(req_ready), 0, 0);
                cyc = 0; busy = INIT - 1; phase = 0; pend = 0; tim_on = 0;
                tcount = 0; m_init = 0; m_open = 0;
                exp_q.delete(); dram_q.delete();
                continue;
            end
            cyc++;
            e_cmd = C_NOP; e_addr = 0; chk_a = 0; e_oe = 0; e_wd = 0;
            e_dqm = m_init ? 2'b00 : 2'b11;
            tag = "R3"; mrs_now = 0;
            rb = req_addr[21:20]; rr = req_addr[19:8]; rc = req_addr[7:0];
            if (busy > 0) begin
                busy--;
                tag = (phase < 4) ? "R2" : "R7";
            end else begin
                case (phase)
                    0: begin e_cmd = C_PRE; e_addr = 14'h0400; chk_a = 1; busy = RP - 1; phase = 1; tag = "R2"; end
                    1: begin e_cmd = C_REF; busy = RFC - 1; phase = 2; tag = "R2"; end
                    2: begin e_cmd = C_REF; busy = RFC - 1; phase = 3; tag = "R2"; end
                    3: begin
                        e_cmd = C_LMR; e_addr = 14'(CL << 4); chk_a = 1;
                        busy = MRD - 1; phase = 4; tag = "R2"; mrs_now = 1;
                    end
                    default: begin
                        if (pend && m_open) begin
                            // R8 close row ahead of refresh
                            e_cmd = C_PRE; e_addr = 14'h0400; chk_a = 1;
                            m_open = 0; busy = RP - 1; tag = "R8";
                        end else if (pend) begin
                            e_cmd = C_REF; pend = 0; busy = RFC - 1; tag = "R8";
                        end else if (req_valid && m_open && rb == ob && rr == orow) begin
                            tag = "R5"; chk_a = 1;
                            e_addr = {rb, 1'b0, req_autopre, 2'b00, rc};
                            k = int'({rb, rr, rc});
                            if (req_we) begin
                                e_cmd = C_WR; e_oe = 1; e_wd = req_wdata; e_dqm = ~req_be;
                                ref_mem[k] = {req_be[1] ? req_wdata[15:8] : ref_rd(k)[15:8],
                                              req_be[0] ? req_wdata[7:0]  : ref_rd(k)[7:0]};
                                busy = WR - 1;
                            end else begin
                                e_cmd = C_RD;
                                exp_q.push_back('{due: cyc + CL + 1, d: ref_rd(k)});
                                busy = CL;
                            end
                            if (req_autopre) begin m_open = 0; busy += RP; end
                        end else if (req_valid && m_open) begin
                            // R6 row miss
                            e_cmd = C_PRE; e_addr = {ob, 12'h000}; chk_a = 1;
                            m_open = 0; busy = RP - 1; tag = "R6";
                        end else if (req_valid) begin
                            // R4 open row
                            e_cmd = C_ACT; e_addr = {rb, rr}; chk_a = 1;
                            m_open = 1; ob = rb; orow = rr; busy = RCD - 1; tag = "R4";
                        end
                    end
                endcase
            end
            // compare every cycle
            chk("R1", "cke", 32'(sd_cke), 1, cyc);
            chk(tag, "cmd", 32'(got_cmd), 32'(e_cmd), cyc);
            if (chk_a) chk(tag, "addr", 32'(sd_addr), 32'(e_addr), cyc);
            chk("R10", "dqm", 32'(sd_dqm), 32'(e_dqm), cyc);
            chk("R5", "dq_oe", 32'(sd_dq_oe), 32'(e_oe), cyc);
            if (e_oe) chk("R5", "wdata", 32'(sd_dq_out), 32'(e_wd), cyc);
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                chk("R9", "rsp_valid", 32'(rsp_valid), 1, cyc);
                chk("R9", "rsp_data", 32'(rsp_data), 32'(exp_q[0].d), cyc);
                void'(exp_q.pop_front());
            end else begin
                chk("R9", "rsp_valid", 32'(rsp_valid), 0, cyc);
            end
            // memory model follows the DUT's own commands
            drow_bank = sd_addr[13:12];
            if (!sd_cs_n) begin
                if (got_cmd == C_ACT) drow[drow_bank] = sd_addr[11:0];
                if (got_cmd == C_WR) begin
                    k = int'({drow_bank, drow[drow_bank], sd_addr[7:0]});
                    dram_mem[k] = {sd_dqm[1] ? dram_rd(k)[15:8] : sd_dq_out[15:8],
                                   sd_dqm[0] ? dram_rd(k)[7:0]  : sd_dq_out[7:0]};
                end
                if (got_cmd == C_RD) begin
                    k = int'({drow_bank, drow[drow_bank], sd_addr[7:0]});
                    dram_q.push_back('{due: cyc + CL, d: dram_rd(k)});
                end
            end
            if (dram_q.size() > 0 && dram_q[0].due == cyc) begin
                sd_dq_in = dram_q[0].d;
                void'(dram_q.pop_front());
            end else begin
                sd_dq_in = 16'hDEAD;
            end
            // refresh interval (R8)
            if (tim_on) begin
                tcount++;
                if (tcount == RINT) begin pend = 1; tcount = 0; end
            end
            if (mrs_now) begin m_init = 1; tim_on = 1; tcount = 0; end
        end
    end

    task automatic send(input bit we, input bit ap, input logic [1:0] b,
                        input logic [11:0] r, input logic [7:0] c,
                        input logic [15:0] d, input logic [1:0] be);
        req_we = we; req_autopre = ap; req_addr = {b, r, c};
        req_wdata = d; req_be = be; req_valid = 1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin : stim
        rst = 1; req_valid = 0; req_we = 0; req_autopre = 0;
        req_addr = 0; req_wdata = 0; req_be = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R4 R5 write into a closed bank, then a row hit with lower byte only
        send(1, 0, 2'd0, 12'h005, 8'h03, 16'h1234, 2'b11);
        send(1, 0, 2'd0, 12'h005, 8'h04, 16'hABCD, 2'b01);
        // R9 read back, second shows byte masking
        send(0, 0, 2'd0, 12'h005, 8'h03, 16'h0, 2'b11);
        send(0, 0, 2'd0, 12'h005, 8'h04, 16'h0, 2'b11);
        // R6 miss, R7 auto-precharge write then read of a closed row
        send(1, 1, 2'd2, 12'h009, 8'h00, 16'h5555, 2'b10);
        send(0, 1, 2'd2, 12'h009, 8'h00, 16'h0, 2'b11);
        // R8 refresh with every bank closed
        repeat (RINT + 20) @(negedge clk);
        // R8 refresh against streaming traffic with rows open
        for (int i = 0; i < 40; i++) begin
            send(i % 3 != 1, i % 7 == 3, 2'((i / 3) % 4), 12'(16 + (i / 2) % 3),
                 8'(i * 13), 16'(i * 16'h1111) ^ 16'h0F0F, 2'((i % 3) + 1));
        end
        // boundary address
        send(1, 0, 2'd3, 12'hFFF, 8'hFF, 16'hBEEF, 2'b11);
        send(0, 1, 2'd3, 12'hFFF, 8'hFF, 16'h0, 2'b11);
        repeat (30) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got %0d cycles expected under %0d",
                     WATCHDOG, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule